// File: doc/BRIEF.md
# Double-Capture Period Measurement Unit

This block timestamps edges of an asynchronous input pin against a shared 16-bit free-running time-base bus. It keeps two capture values, the newest and the one before it, that always belong together. Software can therefore compute the period between two qualifying edges with one subtraction, and it cannot catch the block halfway through an update.

The unit listens to one of two 16-bit time-base buses. A control bit picks which bus is used, and another picks rising or falling edges. On each qualifying edge the sampled bus value enters the newest-sample register A. In the same cycle, the middle stage B1 moves into the previous-sample register B2. One cycle later A is copied into B1. A sticky flag, gated by an enable bit, can raise an interrupt on each capture. The flag can optionally also be raised on the very first capture after the control register is written.

Top module: `period_capture_unit`

## Requirements
- R1: After reset, registers A, B1 and B2, the control register and the flag read as zero, and irq_o is low.
- R2: With the edge bit (control bit 4) at 0, a rising transition of pin_i is captured. The selected bus value present at the third rising clock edge after the pin changes is written into A. Falling transitions are ignored.
- R3: With the edge bit at 1, only falling transitions of pin_i are captured, with the same latency as in R2.
- R4: On a capture, B2 takes the old content of B1 in the same cycle, and B1 takes the new A one cycle later. After each capture, A and B1 therefore hold the newest sample and B2 holds the sample before it.
- R5: The bus-select bit (control bit 5) picks tb1_i when set and tb0_i when clear.
- R6: Captures happen only while the mode field (control bits 3:0) equals 4'b0010. With any other mode value, A, B1, B2 and the flag stay unchanged.
- R7: A capture sets the flag when an earlier capture has happened since the last control write. The first capture after a control write does not set the flag unless R8 applies.
- R8: With the first-edge bit (control bit 6) set, the first capture after a control write also sets the flag.
- R9: Every write to the control register re-arms first-edge tracking, so the next capture counts as the first.
- R10: The flag (read at control bit 8) stays set until a control write with bit 8 at 1 clears it. A control write with bit 8 at 0 leaves it set. irq_o equals the flag ANDed with the interrupt-enable bit (control bit 7).
- R11: Register addresses are 0 for control, 1 for A, 2 for B1 and 3 for B2. Writes to addresses 1 to 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tb0_i | input | 16 | Time-base bus 0 |
| tb1_i | input | 16 | Time-base bus 1 |
| pin_i | input | 1 | Asynchronous measured input |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong pipeline order shows up at the ports two clock cycles after the next capture. Either B2 repeats the newest value, or B1 lags A, and the bench reads both after every edge. Stale first-edge tracking or a wrongly gated flag shows up on the control read and on irq_o within one cycle of the capture that should, or should not, have set the flag. A wrong mode or polarity decode leaves A either unchanged or changed after an edge whose expected effect the bench knows.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int unsigned MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_DCAP = 4'b0010;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_A    = 2'd1;
  localparam logic [1:0] ADDR_B1   = 2'd2;
  localparam logic [1:0] ADDR_B2   = 2'd3;

  localparam int unsigned FLAG_BIT = 8;

  typedef struct packed {
    logic              irq_en;
    logic              first_en;
    logic              bus_sel;
    logic              edge_fall;
    logic [MODE_W-1:0] mode;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pcu_edge_sync.sv
module pcu_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  localparam int unsigned SH_W = STAGES + 1;

  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SH_W-2:0], pin_i};
  end

  logic lvl, prv;
  assign lvl = sh_q[STAGES-1];
  assign prv = sh_q[STAGES];

  always_comb begin
    if (fall_sel_i) edge_o = prv & ~lvl;
    else            edge_o = lvl & ~prv;
  end

  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && $stable(fall_sel_i)) |=> (!edge_o || !$stable(fall_sel_i)));
endmodule

// File: rtl/pcu_capture_pipe.sv
module pcu_capture_pipe #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] tb_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b1_o,
  output logic [W-1:0] b2_o,
  output logic         busy_o
);
  logic [W-1:0] a_q, b1_q, b2_q;
  logic         busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b2_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= cap_i;
      if (cap_i) begin
        a_q  <= tb_i;
        b2_q <= b1_q;
      end
    end
  end

  // second step: A moves into B1 only after B2 has latched
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     b1_q <= '0;
    else if (busy_q) b1_q <= a_q;
  end

  assign a_o    = a_q;
  assign b1_o   = b1_q;
  assign b2_o   = b2_q;
  assign busy_o = busy_q;

  p_b2_takes_b1_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (b2_q == $past(b1_q)));
  p_b1_follows_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> (b1_q == $past(a_q)));
  p_no_cap_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !cap_i);
  p_a_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(a_q));
endmodule

// File: rtl/pcu_flag_ctrl.sv
module pcu_flag_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic first_en_i,
  input  logic rearm_i,
  input  logic clr_i,
  output logic flag_o
);
  logic seen_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_q <= 1'b0;
    else if (rearm_i) seen_q <= 1'b0;
    else if (cap_i)   seen_q <= 1'b1;
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              flag_q <= 1'b0;
    else if (cap_i && (seen_q || first_en_i)) flag_q <= 1'b1;
    else if (clr_i)                           flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && seen_q) |=> flag_q);
  p_first_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !seen_q && !first_en_i && !flag_q) |=> !flag_q);
  p_first_opt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && first_en_i) |=> flag_q);
  p_w1c_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !cap_i) |=> !flag_q);
  p_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/period_capture_unit.sv
module period_capture_unit
  import pcu_pkg::*;
#(
  parameter int unsigned TB_W        = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TB_W-1:0] tb0_i,
  input  logic [TB_W-1:0] tb1_i,
  input  logic            pin_i,
  input  logic            reg_wr_i,
  input  logic [1:0]      reg_addr_i,
  input  logic [TB_W-1:0] reg_wdata_i,
  output logic [TB_W-1:0] reg_rdata_o,
  output logic            irq_o
);
  localparam int unsigned PAD_W = TB_W - FLAG_BIT - 1;

  ctrl_t ctrl_q;
  logic  ctrl_wr;
  logic  edge_det, busy, cap_fire, flag;
  logic [TB_W-1:0] tb_sel, cap_a, cap_b1, cap_b2;

  assign ctrl_wr = reg_wr_i && (reg_addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i[TB_W-1:FLAG_BIT+1];

  pcu_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .fall_sel_i (ctrl_q.edge_fall),
    .edge_o     (edge_det)
  );

  assign tb_sel   = ctrl_q.bus_sel ? tb1_i : tb0_i;
  assign cap_fire = edge_det && (ctrl_q.mode == MODE_DCAP) && !busy;

  pcu_capture_pipe #(.W(TB_W)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap_fire),
    .tb_i   (tb_sel),
    .a_o    (cap_a),
    .b1_o   (cap_b1),
    .b2_o   (cap_b2),
    .busy_o (busy)
  );

  pcu_flag_ctrl u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap_fire),
    .first_en_i (ctrl_q.first_en),
    .rearm_i    (ctrl_wr),
    .clr_i      (ctrl_wr && reg_wdata_i[FLAG_BIT]),
    .flag_o     (flag)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = {{PAD_W{1'b0}}, flag, ctrl_q};
      ADDR_A:    reg_rdata_o = cap_a;
      ADDR_B1:   reg_rdata_o = cap_b1;
      default:   reg_rdata_o = cap_b2;
    endcase
  end

  assign irq_o = flag && ctrl_q.irq_en;

  p_irq_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl_q.irq_en);
  p_mode_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cap_a) |-> ($past(ctrl_q.mode) == MODE_DCAP));
  p_ro_regs_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i != ADDR_CTRL && !busy && !edge_det) |=> $stable(cap_a));
endmodule

// File: tb/period_capture_unit_bench.sv
module period_capture_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tb_cnt;
  logic [15:0] tb0, tb1;
  logic        pin = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_cnt <= 16'h0;
    else        tb_cnt <= tb_cnt + 16'd1;
  end

  function automatic logic [15:0] tbf(input bit bus, input logic [15:0] v);
    int t;
    t = bus ? (int'(v) * 5 + 'h1234) : int'(v);
    return t[15:0];
  endfunction

  assign tb0 = tbf(1'b0, tb_cnt);
  assign tb1 = tbf(1'b1, tb_cnt);

  period_capture_unit u_period_capture_unit (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tb0_i       (tb0),
    .tb1_i       (tb1),
    .pin_i       (pin),
    .reg_wr_i    (wr),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  // model
  logic [15:0] m_a = 0, m_b1 = 0, m_b2 = 0;
  bit m_seen = 0, m_flag = 0;
  logic [7:0] m_ctrl = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wrr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic set_ctrl(input logic [7:0] c, input bit clr);
    wrr(2'd0, {7'b0, clr, c});
    m_ctrl = c;
    m_seen = 0;
    if (clr) m_flag = 0;
  endtask

  task automatic toggle(input int gap);
    logic [15:0] c;
    bit cap;
    @(negedge clk);
    c = tb_cnt;
    pin = ~pin;
    cap = (m_ctrl[3:0] == 4'b0010) && (m_ctrl[4] ? !pin : pin);
    if (cap) begin
      m_b2 = m_b1;
      m_a  = tbf(m_ctrl[5], c + 16'd2);
      m_b1 = m_a;
      if (m_seen || m_ctrl[6]) m_flag = 1;
      m_seen = 1;
    end
    repeat (4 + gap) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic [15:0] d;
    rd(2'd1, d); chk({req, " A"}, d, m_a);
    rd(2'd2, d); chk({req, " B1"}, d, m_b1);
    rd(2'd3, d); chk({req, " B2"}, d, m_b2);
    rd(2'd0, d); chk({req, " flag"}, {15'b0, d[8]}, {15'b0, m_flag});
    chk({req, " irq"}, {15'b0, irq}, {15'b0, m_flag & m_ctrl[7]});
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R1 reset reg", d, 16'h0);
    end
    chk("R1 reset irq", {15'b0, irq}, 16'h0);

    // R2 R3 R4 R5 R7 R8 R9: sweep edge, bus, first-edge option
    for (int cfg = 0; cfg < 8; cfg++) begin
      logic [7:0] c;
      c = {cfg[0] ^ cfg[1], cfg[2], cfg[1], cfg[0], 4'b0010};
      set_ctrl(c, 1'b1);
      check_all("R9 rearm");
      for (int k = 0; k < 6; k++) begin
        toggle(k % 3);
        case (k % 3)
          0: check_all(cfg[0] ? "R3 fall" : "R2 rise");
          1: check_all(cfg[1] ? "R5 bus1" : "R4 pipe");
          default: check_all(cfg[2] ? "R8 first" : "R7 flag");
        endcase
      end
    end

    // R6 mode sweep: only 4'b0010 captures
    for (int m = 0; m < 16; m++) begin
      if (m == 2) continue;
      set_ctrl({4'b1000, m[3:0]}, 1'b1);
      toggle(0);
      toggle(1);
      check_all("R6 mode");
    end

    // R10 sticky flag and W1C
    set_ctrl(8'h82, 1'b1);
    toggle(0); toggle(0); toggle(0);
    check_all("R10 set");
    set_ctrl(8'h82, 1'b0);
    check_all("R10 keep");
    set_ctrl(8'h02, 1'b0);
    check_all("R10 gate");
    set_ctrl(8'h82, 1'b1);
    check_all("R10 clear");

    // R11 read-only capture registers
    toggle(0); toggle(0);
    wrr(2'd1, 16'hdead);
    wrr(2'd2, 16'hbeef);
    wrr(2'd3, 16'h5a5a);
    check_all("R11 ro");

    finish_run();
  end
endmodule